// File: doc/BRIEF.md
# Condition Register Bit Logic Unit

This unit combines two single-bit conditions held in a 32-bit condition register and writes the Boolean result into a third bit. Every other bit keeps its value. A controller can fold several compare outcomes into one bit this way, and a single conditional branch then tests that bit. Each request carries the current register contents, an operation code, two source bit indices and a destination bit index. On a valid strobe the updated register is captured into the output flop.

Bits are numbered from the most significant end. Index 0 names the top bit of the register, and index 31 names the bottom bit. There is also a field mode, enabled by a parameter, which copies one aligned 4-bit field of the register into another field. Instruction decode is done elsewhere. This block only receives decoded selects.

Top module: `cr_bitop_unit`

## Requirements
- R1: While reset is active, and at the first clock edge after reset is released, cr_o is all zeros.
- R2: In a cycle where valid_i is low, cr_o keeps its value at the next clock edge.
- R3: A bit index k refers to cr_i[31-k] and cr_o[31-k]. Index 0 is the most significant bit.
- R4: With field_mode_i low, op_i selects the operation. The codes are 0 and, 2 equivalence (xnor), 5 or, 7 xor. The result is computed from bit A (index src_a_i) and bit B (index src_b_i).
- R5: Code 3 gives not-and and code 4 gives not-or of bits A and B.
- R6: In the complement variants, bit B is the inverted operand. Code 1 gives A and not B. Code 6 gives A or not B.
- R7: In a bit operation, every bit of cr_o other than the destination bit equals the matching bit of cr_i.
- R8: When the destination index equals a source index, the source value used is the incoming value of cr_i, not the result.
- R9: With field_mode_i high, the 4-bit field numbered dst_i[2:0] receives a copy of the field numbered src_a_i[2:0]. Field n covers index bits 4n to 4n+3. All other fields are copied from cr_i. op_i and src_b_i have no effect in this mode.
- R10: The result of a request with valid_i high appears on cr_o directly after the clock edge that samples it. There is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe; when high, cr_o captures the result |
| field_mode_i | input | 1 | 1 selects the field copy, 0 selects the bit operation |
| op_i | input | 3 | Boolean operation code |
| src_a_i | input | 5 | First source bit index, or source field number in its low 3 bits |
| src_b_i | input | 5 | Second source bit index |
| dst_i | input | 5 | Destination bit index, or destination field number in its low 3 bits |
| cr_i | input | 32 | Current condition register contents |
| cr_o | output | 32 | Registered, updated condition register |

## Verification
An internal error shows up on cr_o one cycle after the request that triggers it. A mistake in the bit numbering moves the written bit to a mirrored position. A wrong operation code corrupts only the destination bit. A merge error disturbs the neighbouring bits. Because cr_o is rebuilt from cr_i on every request, a corrupted value does not carry over into later requests. Any fault is therefore visible only in the cycle right after the faulty request, and the bench compares cr_o against a computed register value after every request.

// File: rtl/cr_bitop_pkg.sv
package cr_bitop_pkg;

   typedef enum logic [2:0] {
      OP_AND  = 3'd0,
      OP_ANDC = 3'd1,
      OP_EQV  = 3'd2,
      OP_NAND = 3'd3,
      OP_NOR  = 3'd4,
      OP_OR   = 3'd5,
      OP_ORC  = 3'd6,
      OP_XOR  = 3'd7
   } crop_e;

   localparam int unsigned OP_W = 3;

endpackage

// File: rtl/cr_bit_pick.sv
module cr_bit_pick #(
   parameter int unsigned CR_W  = 32,
   localparam int unsigned IDX_W = $clog2(CR_W)
) (
   input  logic [CR_W-1:0]  cr_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             bit_o
);

   // reorder so that index 0 addresses the most significant bit
   logic [CR_W-1:0] msb_first;

   for (genvar m = 0; m < CR_W; m++) begin : g_rev
      assign msb_first[m] = cr_i[CR_W-1-m];
   end

   assign bit_o = msb_first[idx_i];

endmodule

// File: rtl/cr_bool_alu.sv
module cr_bool_alu
   import cr_bitop_pkg::*;
(
   input  crop_e op_i,
   input  logic  a_i,
   input  logic  b_i,
   output logic  y_o
);

   always_comb begin
      unique case (op_i)
         OP_AND:  y_o = a_i & b_i;
         OP_ANDC: y_o = a_i & ~b_i;
         OP_EQV:  y_o = ~(a_i ^ b_i);
         OP_NAND: y_o = ~(a_i & b_i);
         OP_NOR:  y_o = ~(a_i | b_i);
         OP_OR:   y_o = a_i | b_i;
         OP_ORC:  y_o = a_i | ~b_i;
         OP_XOR:  y_o = a_i ^ b_i;
         default: y_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/cr_bit_merge.sv
module cr_bit_merge #(
   parameter int unsigned CR_W  = 32,
   localparam int unsigned IDX_W = $clog2(CR_W)
) (
   input  logic [CR_W-1:0]  cr_i,
   input  logic [IDX_W-1:0] dst_i,
   input  logic             bit_i,
   output logic [CR_W-1:0]  cr_o
);

   for (genvar j = 0; j < CR_W; j++) begin : g_slot
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(CR_W-1-j);
      assign cr_o[j] = (dst_i == MY_IDX) ? bit_i : cr_i[j];
   end

endmodule

// File: rtl/cr_field_mover.sv
module cr_field_mover #(
   parameter int unsigned CR_W   = 32,
   parameter int unsigned FLD_W  = 4,
   localparam int unsigned FLD_N  = CR_W / FLD_W,
   localparam int unsigned FIDX_W = $clog2(FLD_N)
) (
   input  logic [CR_W-1:0]   cr_i,
   input  logic [FIDX_W-1:0] src_f_i,
   input  logic [FIDX_W-1:0] dst_f_i,
   output logic [CR_W-1:0]   cr_o
);

   logic [FLD_W-1:0] fld [FLD_N];
   logic [FLD_W-1:0] moved;

   for (genvar m = 0; m < FLD_N; m++) begin : g_fld
      localparam int unsigned TOP = CR_W-1-m*FLD_W;
      assign fld[m] = cr_i[TOP -: FLD_W];
      assign cr_o[TOP -: FLD_W] = (dst_f_i == FIDX_W'(m)) ? moved : fld[m];
   end

   assign moved = fld[src_f_i];

endmodule

// File: rtl/cr_bitop_unit.sv
module cr_bitop_unit
   import cr_bitop_pkg::*;
#(
   parameter int unsigned CR_W           = 32,
   parameter int unsigned FLD_W          = 4,
   parameter bit          HAS_FIELD_MOVE = 1'b1,
   localparam int unsigned IDX_W  = $clog2(CR_W),
   localparam int unsigned FLD_N  = CR_W / FLD_W,
   localparam int unsigned FIDX_W = $clog2(FLD_N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   input  logic               field_mode_i,
   input  logic [OP_W-1:0]    op_i,
   input  logic [IDX_W-1:0]   src_a_i,
   input  logic [IDX_W-1:0]   src_b_i,
   input  logic [IDX_W-1:0]   dst_i,
   input  logic [CR_W-1:0]    cr_i,
   output logic [CR_W-1:0]    cr_o
);

   if (CR_W < 2 || (1 << IDX_W) != CR_W) begin : g_bad_cr_w
      $error("cr_bitop_unit: CR_W must be a power of two");
   end
   if (FLD_W < 1 || (CR_W % FLD_W) != 0 || (1 << FIDX_W) != FLD_N) begin : g_bad_fld_w
      $error("cr_bitop_unit: FLD_W must split CR_W into a power-of-two count");
   end

   logic            bit_a, bit_b, bit_res;
   logic [CR_W-1:0] bit_path, fld_path, next_cr;

   cr_bit_pick #(.CR_W(CR_W)) i_pick_a (.cr_i(cr_i), .idx_i(src_a_i), .bit_o(bit_a));
   cr_bit_pick #(.CR_W(CR_W)) i_pick_b (.cr_i(cr_i), .idx_i(src_b_i), .bit_o(bit_b));

   cr_bool_alu i_alu (
      .op_i (crop_e'(op_i)),
      .a_i  (bit_a),
      .b_i  (bit_b),
      .y_o  (bit_res)
   );

   cr_bit_merge #(.CR_W(CR_W)) i_merge (
      .cr_i  (cr_i),
      .dst_i (dst_i),
      .bit_i (bit_res),
      .cr_o  (bit_path)
   );

   if (HAS_FIELD_MOVE) begin : g_fmove
      cr_field_mover #(.CR_W(CR_W), .FLD_W(FLD_W)) i_mover (
         .cr_i    (cr_i),
         .src_f_i (src_a_i[FIDX_W-1:0]),
         .dst_f_i (dst_i[FIDX_W-1:0]),
         .cr_o    (fld_path)
      );
      assign next_cr = field_mode_i ? fld_path : bit_path;
   end else begin : g_no_fmove
      assign fld_path = '0;
      assign next_cr  = bit_path;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cr_o <= '0;
      end else if (valid_i) begin
         cr_o <= next_cr;
      end
   end

endmodule

// File: rtl/cr_bitop_checker.sv
module cr_bitop_checker #(
   parameter int unsigned CR_W           = 32,
   parameter int unsigned FLD_W          = 4,
   parameter bit          HAS_FIELD_MOVE = 1'b1,
   localparam int unsigned IDX_W  = $clog2(CR_W),
   localparam int unsigned FLD_N  = CR_W / FLD_W,
   localparam int unsigned FIDX_W = $clog2(FLD_N)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             valid_i,
   input logic             field_mode_i,
   input logic [2:0]       op_i,
   input logic [IDX_W-1:0] src_a_i,
   input logic [IDX_W-1:0] src_b_i,
   input logic [IDX_W-1:0] dst_i,
   input logic [CR_W-1:0]  cr_i,
   input logic [CR_W-1:0]  cr_o
);

   function automatic logic bit_at(logic [CR_W-1:0] c, logic [IDX_W-1:0] k);
      logic r = 1'b0;
      for (int p = 0; p < CR_W; p++) if (p == CR_W-1-int'(k)) r = c[p];
      return r;
   endfunction

   function automatic logic [CR_W-1:0] one_hot(logic [IDX_W-1:0] k);
      logic [CR_W-1:0] r = '0;
      for (int p = 0; p < CR_W; p++) if (p == CR_W-1-int'(k)) r[p] = 1'b1;
      return r;
   endfunction

   function automatic logic model(logic [2:0] op, logic a, logic b);
      case (op)
         3'd0: return a && b;
         3'd1: return a && !b;
         3'd2: return a == b;
         3'd3: return !(a && b);
         3'd4: return !(a || b);
         3'd5: return a || b;
         3'd6: return a || !b;
         default: return a != b;
      endcase
   endfunction

   function automatic logic [FLD_W-1:0] field_at(logic [CR_W-1:0] c, logic [FIDX_W-1:0] f);
      logic [FLD_W-1:0] r = '0;
      for (int n = 0; n < FLD_N; n++) if (n == int'(f)) r = c[CR_W-1-n*FLD_W -: FLD_W];
      return r;
   endfunction

   logic bit_req;
   assign bit_req = valid_i && !(HAS_FIELD_MOVE && field_mode_i);

   // R1
   p_reset_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> cr_o == '0);

   // R2
   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(cr_o));

   // R4, R5, R6, R3 and R8: destination bit follows the operation on the incoming bits
   p_bit_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_req |=> bit_at(cr_o, $past(dst_i)) ==
         model($past(op_i), bit_at($past(cr_i), $past(src_a_i)), bit_at($past(cr_i), $past(src_b_i))));

   // R7
   p_others_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_req |=> ((cr_o ^ $past(cr_i)) & ~one_hot($past(dst_i))) == '0);

   if (HAS_FIELD_MOVE) begin : g_fchk
      // R9
      p_field_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_i && field_mode_i) |=>
            field_at(cr_o, $past(dst_i[FIDX_W-1:0])) == field_at($past(cr_i), $past(src_a_i[FIDX_W-1:0])));
   end

endmodule

bind cr_bitop_unit cr_bitop_checker #(
   .CR_W(CR_W), .FLD_W(FLD_W), .HAS_FIELD_MOVE(HAS_FIELD_MOVE)
) i_cr_bitop_checker (
   .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .field_mode_i(field_mode_i),
   .op_i(op_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
   .cr_i(cr_i), .cr_o(cr_o)
);

// File: tb/test_cr_bitop_unit.sv
module test_cr_bitop_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic        field_mode_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic [4:0]  src_a_i = '0, src_b_i = '0, dst_i = '0;
   logic [31:0] cr_i = '0;
   logic [31:0] cr_o;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   cr_bitop_unit i_cr_bitop_unit (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .field_mode_i(field_mode_i),
      .op_i(op_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
      .cr_i(cr_i), .cr_o(cr_o)
   );

   function automatic logic f_op(logic [2:0] op, logic a, logic b);
      case (op)
         3'd0: return a & b;
         3'd1: return a & ~b;
         3'd2: return ~(a ^ b);
         3'd3: return ~(a & b);
         3'd4: return ~(a | b);
         3'd5: return a | b;
         3'd6: return a | ~b;
         default: return a ^ b;
      endcase
   endfunction

   function automatic logic [31:0] exp_bit(logic [31:0] c, logic [2:0] op,
                                           logic [4:0] a, logic [4:0] b, logic [4:0] d);
      logic [31:0] r = c;
      r[31 - d] = f_op(op, c[31 - a], c[31 - b]);
      return r;
   endfunction

   function automatic logic [31:0] exp_fld(logic [31:0] c, logic [2:0] s, logic [2:0] d);
      logic [31:0] r = c;
      r[31 - 4*d -: 4] = c[31 - 4*s -: 4];
      return r;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic apply(logic fm, logic [2:0] op, logic [4:0] a, logic [4:0] b,
                        logic [4:0] d, logic [31:0] c);
      @(negedge clk);
      valid_i = 1'b1; field_mode_i = fm; op_i = op;
      src_a_i = a; src_b_i = b; dst_i = d; cr_i = c;
      @(posedge clk);
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   task automatic bitop(string req, logic [2:0] op, logic [4:0] a, logic [4:0] b,
                        logic [4:0] d, logic [31:0] c);
      apply(1'b0, op, a, b, d, c);
      check(req, cr_o, exp_bit(c, op, a, b, d));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%08h expected=%08h", cr_o, cr_o);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] snap;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1 reset value", cr_o, 32'h0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R1 after release", cr_o, 32'h0);

      // R4 R5 R6: every code under all four operand combinations (src A idx 0 -> bit31, src B idx 1 -> bit30)
      for (int op = 0; op < 8; op++) begin
         for (int ab = 0; ab < 4; ab++) begin
            logic [31:0] c = {ab[1], ab[0], 30'h0};
            string req = (op == 1 || op == 6) ? "R6 complement" :
                         (op == 3 || op == 4) ? "R5 inverted" : "R4 op";
            bitop(req, 3'(op), 5'd0, 5'd1, 5'd16, c);
         end
      end

      // R3: index 0 is the MSB, index 31 the LSB
      bitop("R3 msb dest", 3'd5, 5'd31, 5'd31, 5'd0, 32'h0000_0001);
      check("R3 msb value", cr_o, 32'h8000_0001);
      bitop("R3 lsb dest", 3'd0, 5'd0, 5'd0, 5'd31, 32'h8000_0000);
      check("R3 lsb value", cr_o, 32'h8000_0001);

      // R7: surrounding bits untouched
      bitop("R7 neighbours", 3'd3, 5'd4, 5'd4, 5'd4, 32'hFFFF_FFFF);
      check("R7 one bit cleared", cr_o, 32'hF7FF_FFFF);

      // R8: destination equal to a source uses the old value
      bitop("R8 dst=src", 3'd7, 5'd9, 5'd10, 5'd9, 32'h0060_0000);
      bitop("R8 dst=srcb", 3'd1, 5'd2, 5'd2, 5'd2, 32'h2000_0000);
      check("R8 andc self", cr_o, 32'h0);

      // R2: idle cycles leave cr_o unchanged while inputs move
      snap = cr_o;
      @(negedge clk);
      cr_i = 32'hDEAD_BEEF; dst_i = 5'd3; op_i = 3'd5;
      repeat (3) @(negedge clk);
      check("R2 hold", cr_o, snap);

      // R9: field copies, including same field and extremes; op/src_b random
      apply(1'b1, 3'd3, 5'd0, 5'd17, 5'd7, 32'hA000_0005);
      check("R9 field 0 to 7", cr_o, 32'hA000_000A);
      apply(1'b1, 3'd6, 5'd5, 5'd2, 5'd5, 32'h1234_5678);
      check("R9 field same", cr_o, 32'h1234_5678);
      apply(1'b1, 3'd0, 5'd7, 5'd9, 5'd0, 32'h0FFF_FFF3);
      check("R9 field 7 to 0", cr_o, 32'h3FFF_FFF3);

      // R10: result visible right after the sampling edge; R4 random mix
      for (int n = 0; n < 400; n++) begin
         logic        fm = ($urandom % 4) == 0;
         logic [2:0]  op = 3'($urandom);
         logic [4:0]  a = 5'($urandom), b = 5'($urandom), d = 5'($urandom);
         logic [31:0] c = $urandom;
         if (($urandom % 8) == 0) d = a;
         apply(fm, op, a, b, d, c);
         if (fm) check("R9 random field", cr_o, exp_fld(c, a[2:0], d[2:0]));
         else    check("R10 R4 random bit", cr_o, exp_bit(c, op, a, b, d));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule